// File: doc/BRIEF.md
# Late-Select Two-Way Read Path

This block is the read and write front end of a memory split into two ways. The lowest address bit selects the way. On a read it is not sampled with the rest of the address but one clock edge later. The upper address is registered on the first edge, and both ways are read in parallel during the following cycle. The way bit sampled on the second edge then picks which half of the double-width internal word goes into the output register. Read data therefore appears one cycle after the upper address, with the way choice made as late as possible.

Writes present the whole address, way bit included, in one cycle, and the write data follows one cycle later. The completed write waits in a one-entry buffer. The array is updated only when the next write's data arrives. Each way has its own compare against the buffer, so a read of the buffered location returns the buffered word. A read of the same upper address in the other way does not take the bypass. A parameter chooses where the way multiplexer sits: in front of the output register (default), or behind it, driven by the registered way bit.

Top module: `late_sel_ram`

## Requirements
- R1: A read (sel_i=1, we_i=0) registers addr_i on edge n and way_i on edge n+1. After edge n+1, rvalid_o is 1 and rdata_o holds the word of way way_i (0 or 1) at that upper address, for one cycle.
- R2: The value of way_i on a read's own edge n has no effect on that read's data.
- R3: A write (sel_i=1, we_i=1) takes addr_i and way_i on edge n and wdata_i on edge n+1. Any read whose upper address is sampled on edge n+1 or later returns that word.
- R4: A read whose upper address and late way bit both match the buffered write returns the buffered word, including a read issued on the edge that delivers the write data.
- R5: A read of the buffered upper address in the other way returns that way's stored word, not the buffered word.
- R6: After an edge with sel_i=0, rvalid_o is 0 and rdata_o is all zeros following the next edge, whatever way_i is on that next edge.
- R7: After the edge following a write command, rvalid_o is 0 and rdata_o is all zeros.
- R8: While rst_ni is low and after its release, until a read completes, rvalid_o is 0 and rdata_o is all zeros.
- R9: Back-to-back reads to alternating ways yield one correct result per cycle, with no lost or repeated word.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock, all sampling on rising edge |
| rst_ni | input | 1 | Asynchronous reset, active low |
| sel_i | input | 1 | Command valid for this edge |
| we_i | input | 1 | 1 = write command, 0 = read command |
| addr_i | input | ADDR_W | Upper address (all bits except the way bit) |
| way_i | input | 1 | Way bit: a write's own, or a read's late select one edge after the read |
| wdata_i | input | DATA_W | Write data, one edge after the write command |
| rdata_o | output | DATA_W | Read data, zero when not driven |
| rvalid_o | output | 1 | Output drive enable for rdata_o |

## Verification
The bench reads the same upper address with the way bit on the read's own edge set opposite to the one on the following edge. A design that sampled the way early would return the wrong half. It issues a read on the very edge that delivers write data. A design that compared only against the array would return stale data there. It writes one way and at once reads the other way at the same upper address. A compare that ignored the late way bit would wrongly return the buffered word. Deselected cycles are followed by a toggling way bit, to catch an output register that loads on every edge. Alternating-way back-to-back reads and long random mixes catch pipeline slips.

// File: rtl/lsr_pkg.sv
package lsr_pkg;
  localparam int unsigned NUM_WAYS = 2;
  typedef enum logic [1:0] {CMD_NONE, CMD_READ, CMD_WRITE} cmd_e;
endpackage

// File: rtl/lsr_way_bank.sv
module lsr_way_bank #(
  parameter int unsigned ADDR_W = 4,
  parameter int unsigned DATA_W = 16
) (
  input  logic              clk_i,
  input  logic              we_i,
  input  logic [ADDR_W-1:0] waddr_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  logic [ADDR_W-1:0] raddr_i,
  output logic [DATA_W-1:0] rdata_o
);
  localparam int unsigned DEPTH = 1 << ADDR_W;

  logic [DATA_W-1:0] mem_q [DEPTH];

  always_ff @(posedge clk_i) begin
    if (we_i) mem_q[waddr_i] <= wdata_i;
  end

  // read path settles between address edge and select edge
  assign rdata_o = mem_q[raddr_i];
endmodule

// File: rtl/lsr_wbuf.sv
module lsr_wbuf #(
  parameter int unsigned ADDR_W = 4,
  parameter int unsigned DATA_W = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_req_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              way_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic              commit_o,
  output logic              buf_valid_o,
  output logic [ADDR_W-1:0] buf_addr_o,
  output logic              buf_way_o,
  output logic [DATA_W-1:0] buf_data_o
);
  logic              wr_pend_q;
  logic [ADDR_W-1:0] pend_addr_q;
  logic              pend_way_q;
  logic              buf_valid_q;
  logic [ADDR_W-1:0] buf_addr_q;
  logic              buf_way_q;
  logic [DATA_W-1:0] buf_data_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wr_pend_q   <= 1'b0;
      pend_addr_q <= '0;
      pend_way_q  <= 1'b0;
      buf_valid_q <= 1'b0;
      buf_addr_q  <= '0;
      buf_way_q   <= 1'b0;
      buf_data_q  <= '0;
    end else begin
      wr_pend_q <= wr_req_i;
      if (wr_req_i) begin
        pend_addr_q <= addr_i;
        pend_way_q  <= way_i;
      end
      // data edge: old entry retires to the array, new one takes its place
      if (wr_pend_q) begin
        buf_valid_q <= 1'b1;
        buf_addr_q  <= pend_addr_q;
        buf_way_q   <= pend_way_q;
        buf_data_q  <= wdata_i;
      end
    end
  end

  assign commit_o    = wr_pend_q & buf_valid_q;
  assign buf_valid_o = buf_valid_q;
  assign buf_addr_o  = buf_addr_q;
  assign buf_way_o   = buf_way_q;
  assign buf_data_o  = buf_data_q;

  assert_buf_fill_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_pend_q |=> buf_valid_q);

  assert_buf_hold_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !wr_pend_q |=> ($stable(buf_data_q) && $stable(buf_addr_q) && $stable(buf_way_q)));
endmodule

// File: rtl/lsr_out_stage.sv
module lsr_out_stage
  import lsr_pkg::*;
#(
  parameter int unsigned DATA_W  = 16,
  parameter bit          REG_SEL = 1'b0
) (
  input  logic                             clk_i,
  input  logic                             rst_ni,
  input  logic                             load_i,
  input  logic                             late_way_i,
  input  logic [NUM_WAYS-1:0][DATA_W-1:0]  words_i,
  output logic [DATA_W-1:0]                rdata_o,
  output logic                             rvalid_o
);
  logic vld_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) vld_q <= 1'b0;
    else         vld_q <= load_i;
  end
  assign rvalid_o = vld_q;

  generate
    if (REG_SEL) begin : g_sel_after
      logic [NUM_WAYS-1:0][DATA_W-1:0] words_q;
      logic                            way_q;
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
          words_q <= '0;
          way_q   <= 1'b0;
        end else begin
          words_q <= load_i ? words_i : '0;
          way_q   <= load_i & late_way_i;
        end
      end
      // both inputs settle at the same edge: one transition per cycle
      assign rdata_o = words_q[way_q];
    end else begin : g_sel_before
      logic [DATA_W-1:0] data_q;
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) data_q <= '0;
        else         data_q <= load_i ? words_i[late_way_i] : '0;
      end
      assign rdata_o = data_q;
    end
  endgenerate
endmodule

// File: rtl/late_sel_ram.sv
module late_sel_ram
  import lsr_pkg::*;
#(
  parameter int unsigned ADDR_W  = 4,
  parameter int unsigned DATA_W  = 16,
  parameter bit          REG_SEL = 1'b0
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              sel_i,
  input  logic              we_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              way_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [DATA_W-1:0] rdata_o,
  output logic              rvalid_o
);
  cmd_e cmd_d;
  assign cmd_d = !sel_i ? CMD_NONE : (we_i ? CMD_WRITE : CMD_READ);

  logic              rd_pend_q;
  logic [ADDR_W-1:0] rd_addr_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rd_pend_q <= 1'b0;
      rd_addr_q <= '0;
    end else begin
      rd_pend_q <= (cmd_d == CMD_READ);
      if (cmd_d == CMD_READ) rd_addr_q <= addr_i;
    end
  end

  logic              commit;
  logic              buf_valid;
  logic [ADDR_W-1:0] buf_addr;
  logic              buf_way;
  logic [DATA_W-1:0] buf_data;

  lsr_wbuf #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_wbuf (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .wr_req_i    (cmd_d == CMD_WRITE),
    .addr_i      (addr_i),
    .way_i       (way_i),
    .wdata_i     (wdata_i),
    .commit_o    (commit),
    .buf_valid_o (buf_valid),
    .buf_addr_o  (buf_addr),
    .buf_way_o   (buf_way),
    .buf_data_o  (buf_data)
  );

  logic [NUM_WAYS-1:0][DATA_W-1:0] way_word;
  logic [NUM_WAYS-1:0]             hit;

  for (genvar w = 0; w < NUM_WAYS; w++) begin : g_way
    logic [DATA_W-1:0] bank_rdata;

    lsr_way_bank #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_bank (
      .clk_i   (clk_i),
      .we_i    (commit && (buf_way == w[0])),
      .waddr_i (buf_addr),
      .wdata_i (buf_data),
      .raddr_i (rd_addr_q),
      .rdata_o (bank_rdata)
    );

    // per-way compare: upper address from first edge, way identity fixed per lane
    assign hit[w]      = buf_valid && (buf_addr == rd_addr_q) && (buf_way == w[0]);
    assign way_word[w] = hit[w] ? buf_data : bank_rdata;
  end

  lsr_out_stage #(.DATA_W(DATA_W), .REG_SEL(REG_SEL)) u_out (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .load_i     (rd_pend_q),
    .late_way_i (way_i),
    .words_i    (way_word),
    .rdata_o    (rdata_o),
    .rvalid_o   (rvalid_o)
  );

  assert_read_latency_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sel_i && !we_i) |-> ##2 rvalid_o);

  assert_write_quiet_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sel_i && we_i) |-> ##2 (!rvalid_o && rdata_o == '0));

  assert_desel_quiet_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !sel_i |-> ##2 (!rvalid_o && rdata_o == '0));
endmodule

// File: tb/tb_late_sel_ram.sv
`timescale 1ns/1ps
module tb_late_sel_ram;
  localparam int unsigned AW = 4;
  localparam int unsigned DW = 16;
  localparam int unsigned DEPTH = 1 << AW;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          sel = 1'b0, we = 1'b0, way = 1'b0;
  logic [AW-1:0] addr = '0;
  logic [DW-1:0] wdata = '0;
  logic [DW-1:0] rdata;
  logic          rvalid;

  always #2 clk = ~clk;

  late_sel_ram #(.ADDR_W(AW), .DATA_W(DW)) dut (
    .clk_i(clk), .rst_ni(rst_n), .sel_i(sel), .we_i(we), .addr_i(addr),
    .way_i(way), .wdata_i(wdata), .rdata_o(rdata), .rvalid_o(rvalid)
  );

  int n_chk = 0, n_bad = 0;
  string tag = "R8";
  bit done = 0;

  logic [DW-1:0] model [2][DEPTH];
  logic          exp_v = 0;
  logic [DW-1:0] exp_d = '0;
  logic          prd = 0, pwr = 0, pw_way = 0;
  logic [AW-1:0] pw_addr = '0;
  logic [DW-1:0] snap0 = '0, snap1 = '0;

  task automatic check_out();
    n_chk++;
    if (rvalid !== exp_v || rdata !== exp_d) begin
      n_bad++;
      $display("FAIL %s: rvalid=%0b rdata=%h expected rvalid=%0b rdata=%h",
               tag, rvalid, rdata, exp_v, exp_d);
    end
  endtask

  task automatic model_edge(input logic s, input logic w, input logic [AW-1:0] a,
                            input logic wy, input logic [DW-1:0] wd);
    if (prd) begin exp_v = 1'b1; exp_d = wy ? snap1 : snap0; end
    else     begin exp_v = 1'b0; exp_d = '0; end
    if (pwr) model[pw_way][pw_addr] = wd;
    prd = s && !w;
    if (prd) begin snap0 = model[0][a]; snap1 = model[1][a]; end
    pwr = s && w;
    if (pwr) begin pw_addr = a; pw_way = wy; end
  endtask

  task automatic cyc(input logic s, input logic w, input logic [AW-1:0] a,
                     input logic wy, input logic [DW-1:0] wd);
    @(negedge clk);
    check_out();
    sel = s; we = w; addr = a; way = wy; wdata = wd;
    @(posedge clk);
    model_edge(s, w, a, wy, wd);
  endtask

  task automatic summary();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog: cycles=200000 expected completion earlier");
      summary();
    end
  end

  initial begin
    void'($urandom(32'h5eed_1234));
    for (int w = 0; w < 2; w++)
      for (int a = 0; a < DEPTH; a++) model[w][a] = '0;
    repeat (3) @(posedge clk);
    // R8: outputs quiet in and after reset
    tag = "R8";
    @(negedge clk); check_out();
    rst_n = 1'b1;
    cyc(0, 0, '0, 0, '0);
    cyc(0, 0, '0, 0, '0);

    // R3/R7: fill every location, outputs stay quiet
    tag = "R3_R7";
    for (int w = 0; w < 2; w++)
      for (int a = 0; a < DEPTH; a++)
        cyc(1, 1, a[AW-1:0], w[0], DW'($urandom));
    cyc(0, 0, '0, 0, DW'($urandom));
    cyc(0, 0, '0, 0, '0);

    // R1/R9: back-to-back reads, alternating ways
    tag = "R1_R9";
    for (int a = 0; a < DEPTH; a++) cyc(1, 0, a[AW-1:0], a[0], '0);
    cyc(0, 0, '0, 1, '0);
    cyc(0, 0, '0, 0, '0);

    // R2: early way bit opposite to late way bit
    tag = "R2";
    cyc(1, 0, 4'd5, 1, '0);
    cyc(1, 0, 4'd6, 0, '0);
    cyc(0, 0, '0, 1, '0);
    cyc(0, 0, '0, 0, '0);

    // R4: read on the data edge hits the buffer
    tag = "R4";
    cyc(1, 1, 4'd9, 0, '0);
    cyc(1, 0, 4'd9, 1, 16'hA5C3);
    cyc(1, 0, 4'd9, 0, '0);
    cyc(0, 0, '0, 0, '0);
    cyc(0, 0, '0, 0, '0);

    // R5: same upper address, other way, no bypass
    tag = "R5";
    cyc(1, 1, 4'd3, 0, '0);
    cyc(1, 0, 4'd3, 0, 16'h0F0F);
    cyc(0, 0, '0, 1, '0);
    cyc(1, 0, 4'd3, 0, '0);
    cyc(0, 0, '0, 0, '0);
    cyc(0, 0, '0, 0, '0);

    // R6: deselect followed by toggling way bit
    tag = "R6";
    for (int i = 0; i < 6; i++) cyc(0, 0, i[AW-1:0], i[0], DW'($urandom));
    cyc(0, 0, '0, 0, '0);

    // random mix covering R1 R3 R4 R5 R7 R9
    tag = "R1_R3_R4_R5_R7_R9";
    for (int i = 0; i < 3000; i++) begin
      logic [3:0] r;
      r = 4'($urandom);
      cyc(r != 0, r[0] & r[1], AW'($urandom_range(0, 3)), 1'($urandom), DW'($urandom));
    end
    cyc(0, 0, '0, 0, '0);
    cyc(0, 0, '0, 0, '0);
    @(negedge clk); check_out();
    done = 1;
    summary();
  end
endmodule